// File: doc/BRIEF.md
# Stereo Audio Transmit FIFO

This block buffers stereo audio samples between a system bus and an audio serializer. Each slot holds one left and one right sample. Software or a DMA engine fills the queue, and the serializer drains it one stereo pair per pop request. Two write styles are supported, chosen by a mode input. In packed mode, one 32-bit write carries a whole pair. In split mode, two halfword writes arrive, the left half first and the right half second, as two DMA channels of different priority would deliver them.

Three fill-level causes are derived from the current occupancy: queue drained, at least half the slots free, and at least one slot free. Each cause is masked by its own enable, and the unmasked causes are ORed onto one interrupt line. The one-free cause is also driven, unmasked, as a DMA request shared by two channels. Sticky flags record writes lost to a full queue and pops made from an empty one.

Top module: `stereo_tx_fifo`

## Requirements
- R1: After reset the fill count is 0, `fifoEmpty` is 1, `fifoFull`, `overflowFlag` and `underrunFlag` are 0, and `popLeft`/`popRight` are 0.
- R2: With `cfgSplit`=0, a write with `wrSize`=2'b10 and `wrAddrHi`=0 pushes one slot: `wrData[15:0]` is the left sample and `wrData[31:16]` is the right sample. Slots leave in the order they were written.
- R3: With `cfgSplit`=1, a write with `wrSize`=2'b01 and `wrAddrHi`=0 stores `wrData[15:0]` as a staged left sample and does not change the fill count. A write with `wrSize`=2'b01 and `wrAddrHi`=1 commits one slot whose right sample is `wrData[15:0]` and whose left sample is the staged value.
- R4: The following writes leave the queue unchanged: a byte write (`wrSize`=2'b00) in either mode, a halfword write in packed mode, and a word write in split mode.
- R5: The queue holds 4 slots. `fillCount` reports 0 to 4, `fifoFull` is 1 exactly at 4, and `fifoEmpty` is 1 exactly at 0.
- R6: A push while the queue is full is dropped, and the stored slots stay as they were. It sets `overflowFlag`, which then stays set until reset.
- R7: A pop while the queue is empty leaves the fill count at 0 and makes `popLeft`/`popRight` zero. It sets `underrunFlag`, which then stays set until reset.
- R8: `irqCause` bit 0 is 1 when the count is 0. Bit 1 is 1 when 2 or more slots are free. Bit 2 is 1 when at least 1 slot is free.
- R9: `irq` is the OR of `irqCause & irqEn`. It follows the fill count in the same cycle in which the count changes.
- R10: `dmaReq` equals the one-free cause whatever the value of `irqEn`.
- R11: A pop of a non-empty queue shows the head slot on `popLeft`/`popRight` from the clock edge that takes `popReq`.
- R12: A push and a pop in the same cycle, on a queue that is neither empty nor full, leave the fill count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgSplit | input | 1 | 0 selects packed word writes, 1 selects split halfword writes |
| wrEn | input | 1 | Bus write strobe for the data port |
| wrSize | input | 2 | Access size: 00 byte, 01 halfword, 10 word |
| wrAddrHi | input | 1 | Address bit 1: 0 selects the base/left half, 1 selects the right half |
| wrData | input | 32 | Write data |
| popReq | input | 1 | Serializer request for the next stereo pair |
| irqEn | input | 3 | Enable per cause: bit0 drained, bit1 half free, bit2 one free |
| popLeft | output | 16 | Left sample of the last popped slot |
| popRight | output | 16 | Right sample of the last popped slot |
| fillCount | output | 3 | Occupied slots |
| fifoFull | output | 1 | All slots occupied |
| fifoEmpty | output | 1 | No slot occupied |
| overflowFlag | output | 1 | Sticky: a push was dropped |
| underrunFlag | output | 1 | Sticky: a pop hit an empty queue |
| irqCause | output | 3 | Raw fill-level causes |
| irq | output | 1 | Masked interrupt |
| dmaReq | output | 1 | DMA request, the one-free cause |

## Verification
The bench pushes a fifth slot into a full queue and then drains it. A design that overwrote a stored slot would return the intruding word, and one that wrapped its counter would report an empty queue. It issues a pop on an empty queue after non-zero data was popped, which catches a design that keeps showing the stale pair. It checks that a staged left half alone does not raise the count, and that every wrong-size write is ignored. A decoder that accepted a halfword as a packed word would add a slot there. It walks the fill count through every level with different enable masks, and does a push and a pop in the same cycle. This exposes off-by-one thresholds in the half-free cause, a masked DMA request, and a counter that misses the combined update.

// File: rtl/stereo_fifo_pkg.sv
package stereo_fifo_pkg;

  localparam logic [1:0] SZ_BYTE = 2'b00;
  localparam logic [1:0] SZ_HALF = 2'b01;
  localparam logic [1:0] SZ_WORD = 2'b10;

  localparam int CAUSE_DRAINED  = 0;
  localparam int CAUSE_HALFFREE = 1;
  localparam int CAUSE_ONEFREE  = 2;
  localparam int CAUSE_N        = 3;

  // Strobes from control to datapath, one cycle wide each.
  typedef struct packed {
    logic pushPacked;  // commit a whole word as one slot
    logic pushSplit;   // commit staged left plus incoming right half
    logic stageLeft;   // capture a left half into the staging register
    logic popHead;     // read the head slot into the output register
    logic popEmpty;    // pop on an empty queue: clear the output register
  } fifoStrobesT;

endpackage

// File: rtl/stereo_fifo_ctrl.sv
module stereo_fifo_ctrl
  import stereo_fifo_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cfgSplit,
  input  logic               wrEn,
  input  logic [1:0]         wrSize,
  input  logic               wrAddrHi,
  input  logic               popReq,
  input  logic [CAUSE_N-1:0] irqEn,
  output fifoStrobesT        strobes,
  output logic [PTR_W-1:0]   wrPtr,
  output logic [PTR_W-1:0]   rdPtr,
  output logic [CNT_W-1:0]   fillCount,
  output logic               fifoFull,
  output logic               fifoEmpty,
  output logic               overflowFlag,
  output logic               underrunFlag,
  output logic [CAUSE_N-1:0] irqCause,
  output logic               irq,
  output logic               dmaReq
);

  localparam logic [CNT_W-1:0] CNT_MAX   = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] HALF_FREE = CNT_W'(DEPTH / 2);
  localparam logic [PTR_W-1:0] PTR_LAST  = PTR_W'(DEPTH - 1);

  logic wordOk, halfOk, rightWr, pushReq, pushDo, popDo;
  logic [CNT_W-1:0] freeSlots;

  // Access decode: each mode accepts one access size only.
  always_comb begin
    wordOk  = wrEn && !cfgSplit && (wrSize == SZ_WORD) && !wrAddrHi;
    halfOk  = wrEn &&  cfgSplit && (wrSize == SZ_HALF);
    rightWr = halfOk && wrAddrHi;
    pushReq = wordOk || rightWr;
    pushDo  = pushReq && !fifoFull;
    popDo   = popReq && !fifoEmpty;
  end

  always_comb begin
    strobes.pushPacked = wordOk && !fifoFull;
    strobes.pushSplit  = rightWr && !fifoFull;
    strobes.stageLeft  = halfOk && !wrAddrHi;
    strobes.popHead    = popDo;
    strobes.popEmpty   = popReq && fifoEmpty;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      fillCount <= '0;
      overflowFlag <= 1'b0;
      underrunFlag <= 1'b0;
    end else begin
      if (pushDo) wrPtr <= (wrPtr == PTR_LAST) ? '0 : wrPtr + 1'b1;
      if (popDo)  rdPtr <= (rdPtr == PTR_LAST) ? '0 : rdPtr + 1'b1;
      case ({pushDo, popDo})
        2'b10:   fillCount <= fillCount + 1'b1;
        2'b01:   fillCount <= fillCount - 1'b1;
        default: fillCount <= fillCount;
      endcase
      if (pushReq && fifoFull)    overflowFlag <= 1'b1;
      if (popReq && fifoEmpty)    underrunFlag <= 1'b1;
    end
  end

  // Level decode, recomputed every cycle from the live count.
  always_comb begin
    fifoFull  = (fillCount == CNT_MAX);
    fifoEmpty = (fillCount == '0);
    freeSlots = CNT_MAX - fillCount;
    irqCause[CAUSE_DRAINED]  = fifoEmpty;
    irqCause[CAUSE_HALFFREE] = (freeSlots >= HALF_FREE);
    irqCause[CAUSE_ONEFREE]  = !fifoFull;
    irq    = |(irqCause & irqEn);
    dmaReq = irqCause[CAUSE_ONEFREE];
  end

  assert_count_bound_R5: assert property (@(posedge clk) disable iff (!rstN)
    fillCount <= CNT_MAX);

  assert_drop_on_full_R6: assert property (@(posedge clk) disable iff (!rstN)
    (fifoFull && pushReq && !popReq) |=> (fillCount == CNT_MAX));

  assert_overflow_sticky_R6: assert property (@(posedge clk) disable iff (!rstN)
    overflowFlag |=> overflowFlag);

  assert_underrun_sticky_R7: assert property (@(posedge clk) disable iff (!rstN)
    underrunFlag |=> underrunFlag);

  assert_both_ops_hold_R12: assert property (@(posedge clk) disable iff (!rstN)
    (pushReq && popReq && !fifoFull && !fifoEmpty) |=> $stable(fillCount));

endmodule

// File: rtl/stereo_fifo_datapath.sv
module stereo_fifo_datapath
  import stereo_fifo_pkg::*;
#(
  parameter int DEPTH    = 4,
  parameter int SAMPLE_W = 16,
  localparam int PTR_W   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int ENTRY_W = 2 * SAMPLE_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  fifoStrobesT        strobes,
  input  logic [PTR_W-1:0]   wrPtr,
  input  logic [PTR_W-1:0]   rdPtr,
  input  logic [ENTRY_W-1:0] wrData,
  output logic [SAMPLE_W-1:0] popLeft,
  output logic [SAMPLE_W-1:0] popRight
);

  logic [ENTRY_W-1:0]  slotMem [DEPTH];
  logic [SAMPLE_W-1:0] stagedLeft;
  logic [ENTRY_W-1:0]  pushEntry;
  logic [ENTRY_W-1:0]  outReg;
  logic                pushAny;

  always_comb begin
    pushAny   = strobes.pushPacked || strobes.pushSplit;
    pushEntry = strobes.pushPacked ? wrData
                                   : {wrData[SAMPLE_W-1:0], stagedLeft};
  end

  always_ff @(posedge clk) begin
    if (!rstN) stagedLeft <= '0;
    else if (strobes.stageLeft) stagedLeft <= wrData[SAMPLE_W-1:0];
  end

  generate
    for (genvar s = 0; s < DEPTH; s++) begin : g_slot
      always_ff @(posedge clk) begin
        if (!rstN) slotMem[s] <= '0;
        else if (pushAny && (wrPtr == PTR_W'(s))) slotMem[s] <= pushEntry;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN)                 outReg <= '0;
    else if (strobes.popHead)  outReg <= slotMem[rdPtr];
    else if (strobes.popEmpty) outReg <= '0;
  end

  assign popLeft  = outReg[SAMPLE_W-1:0];
  assign popRight = outReg[ENTRY_W-1:SAMPLE_W];

  assert_underrun_zero_R7: assert property (@(posedge clk) disable iff (!rstN)
    strobes.popEmpty |=> (outReg == '0));

  assert_single_push_R2: assert property (@(posedge clk) disable iff (!rstN)
    !(strobes.pushPacked && strobes.pushSplit));

endmodule

// File: rtl/stereo_tx_fifo.sv
module stereo_tx_fifo
  import stereo_fifo_pkg::*;
#(
  parameter int DEPTH    = 4,
  parameter int SAMPLE_W = 16,
  localparam int PTR_W   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W   = $clog2(DEPTH + 1)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  cfgSplit,
  input  logic                  wrEn,
  input  logic [1:0]            wrSize,
  input  logic                  wrAddrHi,
  input  logic [2*SAMPLE_W-1:0] wrData,
  input  logic                  popReq,
  input  logic [CAUSE_N-1:0]    irqEn,
  output logic [SAMPLE_W-1:0]   popLeft,
  output logic [SAMPLE_W-1:0]   popRight,
  output logic [CNT_W-1:0]      fillCount,
  output logic                  fifoFull,
  output logic                  fifoEmpty,
  output logic                  overflowFlag,
  output logic                  underrunFlag,
  output logic [CAUSE_N-1:0]    irqCause,
  output logic                  irq,
  output logic                  dmaReq
);

  fifoStrobesT       strobes;
  logic [PTR_W-1:0]  wrPtr;
  logic [PTR_W-1:0]  rdPtr;

  stereo_fifo_ctrl #(.DEPTH(DEPTH)) i_ctrl (
    .clk(clk), .rstN(rstN), .cfgSplit(cfgSplit), .wrEn(wrEn),
    .wrSize(wrSize), .wrAddrHi(wrAddrHi), .popReq(popReq), .irqEn(irqEn),
    .strobes(strobes), .wrPtr(wrPtr), .rdPtr(rdPtr),
    .fillCount(fillCount), .fifoFull(fifoFull), .fifoEmpty(fifoEmpty),
    .overflowFlag(overflowFlag), .underrunFlag(underrunFlag),
    .irqCause(irqCause), .irq(irq), .dmaReq(dmaReq)
  );

  stereo_fifo_datapath #(.DEPTH(DEPTH), .SAMPLE_W(SAMPLE_W)) i_data (
    .clk(clk), .rstN(rstN), .strobes(strobes), .wrPtr(wrPtr), .rdPtr(rdPtr),
    .wrData(wrData), .popLeft(popLeft), .popRight(popRight)
  );

  assert_dma_needs_room_R10: assert property (@(posedge clk) disable iff (!rstN)
    dmaReq |-> !fifoFull);

  assert_full_empty_exclusive_R5: assert property (@(posedge clk) disable iff (!rstN)
    !(fifoFull && fifoEmpty));

endmodule

// File: tb/test_stereo_tx_fifo.sv
module test_stereo_tx_fifo;

  logic        clk = 1'b0;
  logic        rstN;
  logic        cfgSplit, wrEn, wrAddrHi, popReq;
  logic [1:0]  wrSize;
  logic [31:0] wrData;
  logic [2:0]  irqEn;
  logic [15:0] popLeft, popRight;
  logic [2:0]  fillCount, irqCause;
  logic        fifoFull, fifoEmpty, overflowFlag, underrunFlag, irq, dmaReq;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;  // 50 MHz

  stereo_tx_fifo i_stereo_tx_fifo (
    .clk(clk), .rstN(rstN), .cfgSplit(cfgSplit), .wrEn(wrEn), .wrSize(wrSize),
    .wrAddrHi(wrAddrHi), .wrData(wrData), .popReq(popReq), .irqEn(irqEn),
    .popLeft(popLeft), .popRight(popRight), .fillCount(fillCount),
    .fifoFull(fifoFull), .fifoEmpty(fifoEmpty), .overflowFlag(overflowFlag),
    .underrunFlag(underrunFlag), .irqCause(irqCause), .irq(irq), .dmaReq(dmaReq)
  );

  typedef struct packed {
    logic        sp;
    logic        we;
    logic [1:0]  sz;
    logic        hi;
    logic [31:0] dat;
    logic        pop;
    logic [2:0]  en;
    logic [2:0]  expCnt;
    logic        expIrq;
    logic        expDma;
    logic        chkPop;
    logic [15:0] expL;
    logic [15:0] expR;
  } stepT;

  localparam int NSTEP = 15;
  localparam stepT VEC [NSTEP] = '{
    // sp we  sz    hi  data          pop en     cnt   irq  dma  chk  L        R
    '{1'b0,1'b1,2'b10,1'b0,32'hBBBB_AAAA,1'b0,3'b000,3'd1,1'b0,1'b1,1'b0,16'h0,16'h0},   // R2 R10
    '{1'b0,1'b1,2'b10,1'b0,32'h2222_1111,1'b0,3'b001,3'd2,1'b0,1'b1,1'b0,16'h0,16'h0},   // R8 R9
    '{1'b0,1'b0,2'b00,1'b0,32'h0,        1'b0,3'b010,3'd2,1'b1,1'b1,1'b0,16'h0,16'h0},   // R8 half free
    '{1'b0,1'b1,2'b10,1'b0,32'h4444_3333,1'b0,3'b010,3'd3,1'b0,1'b1,1'b0,16'h0,16'h0},   // R8 R9
    '{1'b0,1'b1,2'b10,1'b0,32'h6666_5555,1'b0,3'b100,3'd4,1'b0,1'b0,1'b0,16'h0,16'h0},   // R5 R10
    '{1'b0,1'b0,2'b00,1'b0,32'h0,        1'b1,3'b100,3'd3,1'b1,1'b1,1'b1,16'hAAAA,16'hBBBB}, // R11
    '{1'b0,1'b0,2'b00,1'b0,32'h0,        1'b1,3'b100,3'd2,1'b1,1'b1,1'b1,16'h1111,16'h2222}, // R11
    '{1'b1,1'b1,2'b01,1'b0,32'h0000_7777,1'b0,3'b000,3'd2,1'b0,1'b1,1'b0,16'h0,16'h0},   // R3 stage
    '{1'b1,1'b1,2'b01,1'b1,32'h0000_8888,1'b0,3'b000,3'd3,1'b0,1'b1,1'b0,16'h0,16'h0},   // R3 commit
    '{1'b1,1'b0,2'b00,1'b0,32'h0,        1'b1,3'b000,3'd2,1'b0,1'b1,1'b1,16'h3333,16'h4444}, // R2 order
    '{1'b1,1'b1,2'b00,1'b1,32'h0000_9999,1'b0,3'b000,3'd2,1'b0,1'b1,1'b0,16'h0,16'h0},   // R4 byte
    '{1'b1,1'b1,2'b10,1'b0,32'hCCCC_DDDD,1'b0,3'b000,3'd2,1'b0,1'b1,1'b0,16'h0,16'h0},   // R4 word in split
    '{1'b1,1'b0,2'b00,1'b0,32'h0,        1'b1,3'b000,3'd1,1'b0,1'b1,1'b1,16'h5555,16'h6666}, // R11
    '{1'b1,1'b0,2'b00,1'b0,32'h0,        1'b1,3'b001,3'd0,1'b1,1'b1,1'b1,16'h7777,16'h8888}, // R3 R9
    '{1'b0,1'b1,2'b01,1'b0,32'h0000_1234,1'b0,3'b001,3'd0,1'b1,1'b1,1'b0,16'h0,16'h0}    // R4 half in packed
  };

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Drive one cycle of stimulus; returns at the following falling edge.
  task automatic cycle(input logic sp, input logic we, input logic [1:0] sz,
                       input logic hi, input logic [31:0] d, input logic pp,
                       input logic [2:0] en);
    @(negedge clk);
    cfgSplit = sp; wrEn = we; wrSize = sz; wrAddrHi = hi; wrData = d;
    popReq = pp; irqEn = en;
    @(negedge clk);
    wrEn = 1'b0; popReq = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rstN = 1'b0; cfgSplit = 1'b0; wrEn = 1'b0; wrSize = 2'b00; wrAddrHi = 1'b0;
    wrData = '0; popReq = 1'b0; irqEn = 3'b000;
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1", "fillCount", 32'(fillCount), 32'd0);
    check("R1", "empty/full", {30'd0, fifoEmpty, fifoFull}, 32'b10);
    check("R1", "sticky flags", {30'd0, overflowFlag, underrunFlag}, 32'd0);
    check("R1", "pop data", {popRight, popLeft}, 32'd0);
    check("R8", "causes at 0", 32'(irqCause), 32'b111);

    for (int i = 0; i < NSTEP; i++) begin
      cycle(VEC[i].sp, VEC[i].we, VEC[i].sz, VEC[i].hi, VEC[i].dat,
            VEC[i].pop, VEC[i].en);
      check($sformatf("step%0d", i), "fillCount", 32'(fillCount), 32'(VEC[i].expCnt));
      check($sformatf("step%0d", i), "irq", 32'(irq), 32'(VEC[i].expIrq));
      check($sformatf("step%0d", i), "dmaReq", 32'(dmaReq), 32'(VEC[i].expDma));
      if (VEC[i].chkPop)
        check($sformatf("step%0d", i), "pop pair", {popRight, popLeft},
              {VEC[i].expR, VEC[i].expL});
    end
    check("R6", "overflow before full", 32'(overflowFlag), 32'd0);
    check("R7", "underrun before empty pop", 32'(underrunFlag), 32'd0);

    // R5/R6: fill all slots, then push a fifth that must be dropped
    for (int k = 0; k < 4; k++)
      cycle(1'b0, 1'b1, 2'b10, 1'b0, {16'hF000 + 16'(k), 16'hE000 + 16'(k)}, 1'b0, 3'b000);
    check("R5", "full flag", {30'd0, fifoFull, fifoEmpty}, 32'b10);
    check("R8", "causes at full", 32'(irqCause), 32'b000);
    cycle(1'b0, 1'b1, 2'b10, 1'b0, 32'hDEAD_BEEF, 1'b0, 3'b111);
    check("R6", "count after drop", 32'(fillCount), 32'd4);
    check("R6", "overflow set", 32'(overflowFlag), 32'd1);
    check("R9", "irq with all enables at full", 32'(irq), 32'd0);
    check("R10", "dmaReq at full", 32'(dmaReq), 32'd0);
    for (int k = 0; k < 4; k++) begin
      cycle(1'b0, 1'b0, 2'b00, 1'b0, 32'd0, 1'b1, 3'b000);
      check("R6", "drained slot", {popRight, popLeft},
            {16'hF000 + 16'(k), 16'hE000 + 16'(k)});
    end
    check("R6", "overflow still set", 32'(overflowFlag), 32'd1);

    // R7: pop on empty after non-zero data
    cycle(1'b0, 1'b0, 2'b00, 1'b0, 32'd0, 1'b1, 3'b000);
    check("R7", "pop data zero", {popRight, popLeft}, 32'd0);
    check("R7", "count stays 0", 32'(fillCount), 32'd0);
    check("R7", "underrun set", 32'(underrunFlag), 32'd1);
    cycle(1'b0, 1'b0, 2'b00, 1'b0, 32'd0, 1'b0, 3'b000);
    check("R7", "underrun sticky", 32'(underrunFlag), 32'd1);

    // R12: push and pop together
    cycle(1'b0, 1'b1, 2'b10, 1'b0, 32'h0B0B_0A0A, 1'b0, 3'b000);
    cycle(1'b0, 1'b1, 2'b10, 1'b0, 32'h0D0D_0C0C, 1'b1, 3'b000);
    check("R12", "count unchanged", 32'(fillCount), 32'd1);
    check("R12", "popped head", {popRight, popLeft}, 32'h0B0B_0A0A);
    cycle(1'b0, 1'b0, 2'b00, 1'b0, 32'd0, 1'b1, 3'b000);
    check("R12", "pushed slot kept", {popRight, popLeft}, 32'h0D0D_0C0C);

    // R3: staged left alone does not add a slot; it survives until the right half
    cycle(1'b1, 1'b1, 2'b01, 1'b0, 32'hFFFF_5A5A, 1'b0, 3'b000);
    check("R3", "left only count", 32'(fillCount), 32'd0);
    cycle(1'b1, 1'b1, 2'b01, 1'b1, 32'hFFFF_A5A5, 1'b0, 3'b000);
    cycle(1'b1, 1'b0, 2'b00, 1'b0, 32'd0, 1'b1, 3'b000);
    check("R3", "split slot", {popRight, popLeft}, 32'hA5A5_5A5A);

    // R1 again: reset clears sticky flags
    @(negedge clk) rstN = 1'b0;
    @(negedge clk) rstN = 1'b1;
    @(negedge clk);
    check("R1", "flags after reset", {30'd0, overflowFlag, underrunFlag}, 32'd0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule